// File: doc/BRIEF.md
# Passive Cycle-Stamped Event Tracer

The tracer sits beside a group of traced sources inside a larger design and records their activity without touching it. Each source offers a valid strobe, an address word and a meta byte. Software picks one source and a meta pattern to watch. Whenever the picked source is valid and its meta byte matches the pattern, the tracer writes one record into a local buffer. A record holds a timestamp, the address and the meta byte. The timestamp comes from a counter inside the tracer that advances on every clock. The traced sources have no input from the tracer, so they cannot be stalled or slowed by it.

Software controls the block through a small register write port. One register holds the capture-enable, readout, clear and timestamp-reset bits. The other registers hold the source select, the meta mask and the meta match value. While readout is set, the tracer raises a freeze output toward the traced system and stops capturing. The host then drains the records, oldest first, with a read strobe. When the buffer is full, new events are dropped and counted, and a sticky overflow flag is set.

The meta byte is laid out as cluster in bits 7:5, processing element in bits 4:2, write in bit 1 (1 = write, 0 = read) and hit in bit 0 (1 = hit, 0 = miss). Only the mask and match registers interpret it.

Top module: `evt_tracer`

## Requirements
- R1: After reset, rec_count_o, overflow_o, drop_count_o, freeze_o and rd_valid_o are all 0, and the timestamp counter is 0.
- R2: A record is stored in a cycle where capture is armed (the enable bit is set and the readout bit is clear), src_valid_i of the selected source is 1, and (meta AND mask) equals (match AND mask). The record holds that source's address and meta byte, and rec_count_o rises by one on the next clock edge. The register addresses are 0 for control, 1 for source select, 2 for mask and 3 for match. The control bits are bit 0 enable, bit 1 readout, bit 2 clear and bit 3 timestamp reset. Clear and timestamp reset act only on the write and are not stored.
- R3: The timestamp stored in a record equals the number of clock edges since reset, or since the last timestamp reset, up to the edge that stores the record.
- R4: Events that qualify on consecutive cycles each produce their own record, one per cycle, with consecutive timestamps.
- R5: While the enable bit is clear, qualifying events leave rec_count_o unchanged.
- R6: While the readout bit is set, freeze_o is 1 and no event is stored. rd_valid_o is 1 while unread records remain, and rd_ts_o, rd_addr_o and rd_meta_o show the oldest unread record. Each rd_req_i cycle advances to the next record.
- R7: When the buffer holds DEPTH records, further qualifying events are not stored. Each one increments drop_count_o, which saturates at its maximum. overflow_o becomes 1 and stays 1 until a clear.
- R8: A clear empties the buffer and sets rec_count_o, overflow_o and drop_count_o to 0. It leaves the timestamp counter running.
- R9: Writing the timestamp-reset bit sets the counter to 0 on that edge. It then counts up by one per cycle from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid_i | input | NSRC | Valid strobe of each traced source |
| src_addr_i | input | NSRC*ADDR_W | Address word of each source; source k uses slice k |
| src_meta_i | input | NSRC*META_W | Meta byte of each source; source k uses slice k |
| ctl_we_i | input | 1 | Register write strobe |
| ctl_addr_i | input | 2 | Register address |
| ctl_wdata_i | input | CFG_W | Register write data |
| freeze_o | output | 1 | Freeze request to the traced system during readout |
| rd_req_i | input | 1 | Advance to the next record during readout |
| rd_valid_o | output | 1 | An unread record is presented |
| rd_ts_o | output | TS_W | Timestamp of the presented record |
| rd_addr_o | output | ADDR_W | Address of the presented record |
| rd_meta_o | output | META_W | Meta byte of the presented record |
| rec_count_o | output | CNT_W | Number of records stored |
| overflow_o | output | 1 | Sticky flag: an event was dropped |
| drop_count_o | output | DROP_W | Number of dropped events, saturating |

## Verification
A wrong write pointer shows up in rec_count_o on the clock edge after the event that moved it. It also shows up later as a missing, duplicated or reordered record when the buffer is drained. A timestamp counter that skips, stalls or clears at the wrong time shows up in every later record's rd_ts_o. The bench compares these values against its own count of clock edges. Faults in the drop counter and the overflow flag are visible on their ports from the first dropped event. The checks after a clear show whether the clear reset each of them.

// File: rtl/evt_trc_pkg.sv
// Package: register addresses and control bit positions of the event tracer.
// Assumes the control register decodes at least four data bits.
package evt_trc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SEL   = 2'd1,
        REG_MASK  = 2'd2,
        REG_MATCH = 2'd3
    } reg_addr_e;

    localparam int CTRL_ENABLE  = 0;
    localparam int CTRL_READOUT = 1;
    localparam int CTRL_CLEAR   = 2;
    localparam int CTRL_TSRST   = 3;
endpackage

// File: rtl/evt_trc_ctrl.sv
// Control registers and the free-running timestamp counter.
// Clear and timestamp reset are write-only actions that apply on the
// write edge. Assumes CFG_W >= META_W, CFG_W >= SEL_W and CFG_W >= 4.
module evt_trc_ctrl #(
    parameter int SEL_W  = 1,
    parameter int META_W = 8,
    parameter int TS_W   = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic              enable_o,
    output logic              readout_o,
    output logic              clr_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [META_W-1:0] mask_o,
    output logic [META_W-1:0] match_o,
    output logic [TS_W-1:0]   ts_o
);
    import evt_trc_pkg::*;

    logic ctrl_wr;
    logic ts_rst;

    // Decode the write actions that take effect on this edge.
    always_comb begin
        ctrl_wr = we_i && (reg_addr_e'(addr_i) == REG_CTRL);
        clr_o   = ctrl_wr && wdata_i[CTRL_CLEAR];
        ts_rst  = ctrl_wr && wdata_i[CTRL_TSRST];
    end

    // Hold the software configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o  <= 1'b0;
            readout_o <= 1'b0;
            sel_o     <= '0;
            mask_o    <= '0;
            match_o   <= '0;
        end else if (we_i) begin
            case (reg_addr_e'(addr_i))
                REG_CTRL: begin
                    enable_o  <= wdata_i[CTRL_ENABLE];
                    readout_o <= wdata_i[CTRL_READOUT];
                end
                REG_SEL:   sel_o   <= wdata_i[SEL_W-1:0];
                REG_MASK:  mask_o  <= wdata_i[META_W-1:0];
                REG_MATCH: match_o <= wdata_i[META_W-1:0];
                default: ;
            endcase
        end
    end

    // Advance the timestamp once per clock, or restart it from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || ts_rst) ts_o <= '0;
        else                  ts_o <= ts_o + 1'b1;
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_rst |=> ts_o == $past(ts_o) + 1'b1);                  // R3
    AST_TS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ts_rst |=> ts_o == '0);                                   // R9
endmodule

// File: rtl/evt_trc_trigger.sv
// Source selection and trigger match, purely combinational.
// A select value beyond the number of sources never fires.
module evt_trc_trigger #(
    parameter int NSRC   = 2,
    parameter int ADDR_W = 32,
    parameter int META_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic [NSRC-1:0]        valid_i,
    input  logic [NSRC*ADDR_W-1:0] addr_i,
    input  logic [NSRC*META_W-1:0] meta_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [META_W-1:0]      mask_i,
    input  logic [META_W-1:0]      match_i,
    output logic                   hit_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [META_W-1:0]      meta_o
);
    logic [ADDR_W-1:0] a_arr [NSRC];
    logic [META_W-1:0] m_arr [NSRC];

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign a_arr[k] = addr_i[k*ADDR_W +: ADDR_W];
        assign m_arr[k] = meta_i[k*META_W +: META_W];
    end

    // Pick the selected source and test its meta byte.
    always_comb begin
        hit_o  = 1'b0;
        addr_o = '0;
        meta_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (int'(sel_i) == k) begin
                addr_o = a_arr[k];
                meta_o = m_arr[k];
                hit_o  = valid_i[k] &&
                         ((m_arr[k] & mask_i) == (match_i & mask_i));
            end
        end
    end
endmodule

// File: rtl/evt_trc_buffer.sv
// Record store with a write pointer that fills once and a read pointer
// that drains oldest first. Events arriving when full are dropped and
// counted. Assumes DEPTH is a power of two.
module evt_trc_buffer #(
    parameter int DEPTH  = 16,
    parameter int REC_W  = 72,
    parameter int DROP_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              evt_i,
    input  logic [REC_W-1:0]  rec_i,
    input  logic              clr_i,
    input  logic              rd_en_i,
    input  logic              rd_req_i,
    output logic [REC_W-1:0]  rd_data_o,
    output logic              rd_valid_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              overflow_o,
    output logic [DROP_W-1:0] drops_o
);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

    logic [REC_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] wptr;
    logic [CNT_W-1:0] rptr;
    logic             full;
    logic             do_wr;
    logic             do_drop;
    logic             do_rd;

    // Qualify the write, drop and read actions of this cycle.
    always_comb begin
        full    = (wptr == FULL_V);
        do_wr   = arm_i && evt_i && !full && !clr_i;
        do_drop = arm_i && evt_i &&  full && !clr_i;
        do_rd   = rd_en_i && rd_req_i && (rptr != wptr) && !clr_i;
    end

    // Store the record at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr[IDX_W-1:0]] <= rec_i;
    end

    // Move the pointers and keep the drop statistics.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wptr       <= '0;
            rptr       <= '0;
            overflow_o <= 1'b0;
            drops_o    <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            if (do_drop) begin
                overflow_o <= 1'b1;
                if (drops_o != '1) drops_o <= drops_o + 1'b1;
            end
        end
    end

    // Present the oldest unread record.
    always_comb begin
        rd_data_o  = mem[rptr[IDX_W-1:0]];
        rd_valid_o = rd_en_i && (rptr != wptr);
        count_o    = wptr;
    end

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && evt_i && !full && !clr_i) |=> wptr == $past(wptr) + 1'b1); // R4
    AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !clr_i) |=> wptr == $past(wptr));                          // R5
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && evt_i && full && !clr_i && drops_o != '1)
        |=> drops_o == $past(drops_o) + 1'b1);                                // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clr_i) |=> overflow_o);                              // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (wptr == '0 && !overflow_o && drops_o == '0));             // R8
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rptr <= wptr);                                                        // R6
endmodule

// File: rtl/evt_tracer.sv
// Top of the event tracer. Joins the control registers, the trigger and
// the record store. The traced sources are inputs only, so the tracer
// cannot hold them back. Capture is armed while enabled and not frozen.
module evt_tracer #(
    parameter int NSRC   = 2,
    parameter int ADDR_W = 32,
    parameter int META_W = 8,
    parameter int TS_W   = 32,
    parameter int DEPTH  = 16,
    parameter int DROP_W = 8,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CFG_W = (META_W > 4) ? META_W : 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REC_W = TS_W + ADDR_W + META_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_valid_i,
    input  logic [NSRC*ADDR_W-1:0] src_addr_i,
    input  logic [NSRC*META_W-1:0] src_meta_i,
    input  logic                   ctl_we_i,
    input  logic [1:0]             ctl_addr_i,
    input  logic [CFG_W-1:0]       ctl_wdata_i,
    output logic                   freeze_o,
    input  logic                   rd_req_i,
    output logic                   rd_valid_o,
    output logic [TS_W-1:0]        rd_ts_o,
    output logic [ADDR_W-1:0]      rd_addr_o,
    output logic [META_W-1:0]      rd_meta_o,
    output logic [CNT_W-1:0]       rec_count_o,
    output logic                   overflow_o,
    output logic [DROP_W-1:0]      drop_count_o
);
    logic              enable;
    logic              readout;
    logic              clr;
    logic [SEL_W-1:0]  sel;
    logic [META_W-1:0] mask;
    logic [META_W-1:0] match;
    logic [TS_W-1:0]   ts;
    logic              hit;
    logic [ADDR_W-1:0] hit_addr;
    logic [META_W-1:0] hit_meta;
    logic [REC_W-1:0]  rd_rec;
    logic              arm;

    evt_trc_ctrl #(.SEL_W(SEL_W), .META_W(META_W), .TS_W(TS_W), .CFG_W(CFG_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .we_i(ctl_we_i), .addr_i(ctl_addr_i),
        .wdata_i(ctl_wdata_i), .enable_o(enable), .readout_o(readout),
        .clr_o(clr), .sel_o(sel), .mask_o(mask), .match_o(match), .ts_o(ts)
    );

    evt_trc_trigger #(.NSRC(NSRC), .ADDR_W(ADDR_W), .META_W(META_W), .SEL_W(SEL_W)) i_trig (
        .valid_i(src_valid_i), .addr_i(src_addr_i), .meta_i(src_meta_i),
        .sel_i(sel), .mask_i(mask), .match_i(match),
        .hit_o(hit), .addr_o(hit_addr), .meta_o(hit_meta)
    );

    // Arm capture only while enabled and not draining.
    always_comb begin
        arm      = enable && !readout;
        freeze_o = readout;
    end

    evt_trc_buffer #(.DEPTH(DEPTH), .REC_W(REC_W), .DROP_W(DROP_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .evt_i(hit),
        .rec_i({ts, hit_addr, hit_meta}), .clr_i(clr),
        .rd_en_i(readout), .rd_req_i(rd_req_i), .rd_data_o(rd_rec),
        .rd_valid_o(rd_valid_o), .count_o(rec_count_o),
        .overflow_o(overflow_o), .drops_o(drop_count_o)
    );

    // Unpack the presented record.
    always_comb begin
        {rd_ts_o, rd_addr_o, rd_meta_o} = rd_rec;
    end
endmodule

// File: tb/test_evt_tracer.sv
`timescale 1ns/1ps
module test_evt_tracer;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_valid = '0;
    logic [63:0] src_addr = '0;
    logic [15:0] src_meta = '0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_addr = '0;
    logic [7:0]  ctl_wdata = '0;
    logic        rd_req = 1'b0;
    logic        freeze, rd_valid, overflow;
    logic [31:0] rd_ts, rd_addr;
    logic [7:0]  rd_meta, drop_count;
    logic [4:0]  rec_count;

    evt_tracer i_evt_tracer (
        .clk(clk), .rst_n(rst_n), .src_valid_i(src_valid), .src_addr_i(src_addr),
        .src_meta_i(src_meta), .ctl_we_i(ctl_we), .ctl_addr_i(ctl_addr),
        .ctl_wdata_i(ctl_wdata), .freeze_o(freeze), .rd_req_i(rd_req),
        .rd_valid_o(rd_valid), .rd_ts_o(rd_ts), .rd_addr_o(rd_addr),
        .rd_meta_o(rd_meta), .rec_count_o(rec_count), .overflow_o(overflow),
        .drop_count_o(drop_count)
    );

    always #4 clk = ~clk;

    // Bench clock-edge count since reset.
    logic [31:0] cyc;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 32'd0;

    int n_cmp = 0, n_err = 0;
    logic        en_m = 0, frz_m = 0;
    logic        sel_m = 0;
    logic [7:0]  mask_m = 0, match_m = 0;
    logic [31:0] ts_off = 0;
    logic [31:0] e_ts [64];
    logic [31:0] e_addr [64];
    logic [7:0]  e_meta [64];
    int e_n = 0, e_drops = 0, r_i = 0;

    // Stimulus table: {valid[1:0], meta0, meta1}; captured with sel 0, mask/match 8'h02.
    localparam logic [17:0] VEC [10] = '{
        {2'b01, 8'h02, 8'h00}, {2'b01, 8'h03, 8'h00}, {2'b01, 8'hE6, 8'h00},
        {2'b01, 8'h01, 8'h00}, {2'b10, 8'h02, 8'h02}, {2'b00, 8'h02, 8'h02},
        {2'b11, 8'h2A, 8'h00}, {2'b11, 8'h00, 8'hFF}, {2'b01, 8'hFE, 8'h00},
        {2'b01, 8'h02, 8'h00}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register write; called and returning at a falling edge.
    task automatic ctl_wr(input logic [1:0] a, input logic [7:0] d);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        case (a)
            2'd0: begin
                en_m = d[0]; frz_m = d[1];
                if (d[2]) begin e_n = 0; e_drops = 0; r_i = 0; end
                if (d[3]) ts_off = cyc;
            end
            2'd1: sel_m = d[0];
            2'd2: mask_m = d;
            default: match_m = d;
        endcase
    endtask

    // One cycle of source activity plus the expected outcome.
    task automatic drive(input logic [1:0] v, input logic [7:0] m0, input logic [7:0] m1,
                         input logic [31:0] a0, input logic [31:0] a1);
        logic [7:0]  sm;
        logic [31:0] sa;
        src_valid = v; src_meta = {m1, m0}; src_addr = {a1, a0};
        sm = sel_m ? m1 : m0;
        sa = sel_m ? a1 : a0;
        if (en_m && !frz_m && v[sel_m] && ((sm & mask_m) == (match_m & mask_m))) begin
            if (e_n < DEPTH) begin
                e_ts[e_n] = cyc - ts_off; e_addr[e_n] = sa; e_meta[e_n] = sm;
                e_n++;
            end else e_drops++;
        end
        @(negedge clk);
        src_valid = '0;
    endtask

    // Drain the remaining records and compare each field.
    task automatic read_all(input string req);
        while (r_i < e_n) begin
            check({req, " rd_valid"}, rd_valid, 1'b1);
            check({req, " ts"}, rd_ts, e_ts[r_i]);
            check({req, " addr"}, rd_addr, e_addr[r_i]);
            check({req, " meta"}, rd_meta, e_meta[r_i]);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            r_i++;
        end
        check({req, " drained"}, rd_valid, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 count", rec_count, 0);
        check("R1 overflow", overflow, 0);
        check("R1 drops", drop_count, 0);
        check("R1 freeze", freeze, 0);
        check("R1 rd_valid", rd_valid, 0);

        // R2/R3/R4: table-driven capture with write-only trigger on source 0
        ctl_wr(2'd1, 8'h00);
        ctl_wr(2'd2, 8'h02);
        ctl_wr(2'd3, 8'h02);
        ctl_wr(2'd0, 8'h01);
        for (int i = 0; i < 10; i++)
            drive(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 32'h1000_0000 + i, 32'h2000_0000 + i);
        check("R2 count", rec_count, e_n);
        check("R2 expected records", e_n, 6);
        // R5: disabled capture ignores a qualifying event
        ctl_wr(2'd0, 8'h00);
        drive(2'b01, 8'h02, 8'h00, 32'hDEAD_0000, 32'h0);
        check("R5 count unchanged", rec_count, 6);
        // R6: freeze and readout
        ctl_wr(2'd0, 8'h03);
        check("R6 freeze", freeze, 1);
        drive(2'b01, 8'h02, 8'h00, 32'hBEEF_0000, 32'h0);
        check("R6 no capture while frozen", rec_count, 6);
        read_all("R2 R3 R6 readout");

        // R7: overflow with back-to-back events on source 1, trigger on all
        ctl_wr(2'd1, 8'h01);
        ctl_wr(2'd2, 8'h00);
        ctl_wr(2'd3, 8'h00);
        ctl_wr(2'd0, 8'h05);
        for (int i = 0; i < 20; i++)
            drive(2'b10, 8'h00, 8'(i), 32'h0, 32'h3000_0000 + i);
        check("R7 count full", rec_count, DEPTH);
        check("R7 overflow", overflow, 1);
        check("R7 drops", drop_count, e_drops);
        check("R7 expected drops", e_drops, 4);
        ctl_wr(2'd0, 8'h02);
        read_all("R4 R7 back-to-back readout");
        check("R7 overflow sticky", overflow, 1);

        // R8: clear resets state, timestamp keeps counting
        ctl_wr(2'd0, 8'h05);
        check("R8 count", rec_count, 0);
        check("R8 overflow", overflow, 0);
        check("R8 drops", drop_count, 0);
        drive(2'b10, 8'h00, 8'h55, 32'h0, 32'h4000_0000);
        ctl_wr(2'd0, 8'h02);
        read_all("R8 timestamp continues");

        // R9: timestamp reset restarts at zero
        ctl_wr(2'd0, 8'h0D);
        drive(2'b10, 8'h00, 8'h11, 32'h0, 32'h5000_0000);
        drive(2'b00, 8'h00, 8'h00, 32'h0, 32'h0);
        drive(2'b00, 8'h00, 8'h00, 32'h0, 32'h0);
        drive(2'b10, 8'h00, 8'h22, 32'h0, 32'h5000_0001);
        ctl_wr(2'd0, 8'h02);
        check("R9 first ts zero", rd_ts, 0);
        read_all("R9 restarted timestamps");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule